// File: doc/BRIEF.md
# On/Off-Count PWM Generator with Committed Counts

This block generates one pulse-width-modulated output from a fixed reference clock. Software does not set a period and a compare value. It sets two independent cycle counts instead: one for the time the output spends high and one for the time it spends low. A full period therefore lasts the high count plus the low count, in reference-clock cycles.

Software reaches the block through a small register port, with a write strobe, an address, write data and combinational read data. A write to a count register only fills a holding (shadow) copy, so the running waveform does not change. A write to the control word moves both held counts into the active copies. The same write restarts the waveform at the beginning of its high phase. The waveform runs only while two control bits are both set: the run bit and the drive bit. Several further control bits are stored and read back but have no effect on the output.

Top module: `pwm_onoff_top`

## Requirements
- R1: After reset, the control word and both count registers read zero and `pwm_out` is low.
- R2: The low-phase count register sits at offset 0x18 and the high-phase count register at offset 0x1C. Each holds 32 bits, and a read returns the value last written to it.
- R3: The control word sits at offset 0x00 and reads back exactly as written. Bits 2, 5, 9 and 10 change nothing on `pwm_out`.
- R4: A write to either count register leaves the running waveform unchanged until the next control-word write.
- R5: The waveform runs only while control bit 0 (run) and control bit 14 (drive) are both set. In any other case `pwm_out` is low.
- R6: While the waveform runs with both counts nonzero, `pwm_out` is high for H cycles and then low for L cycles, repeating. H is the committed high count and L is the committed low count.
- R7: A committed high count of zero holds `pwm_out` low, whatever the low count is, and that includes the case where both counts are zero.
- R8: A committed low count of zero with a nonzero high count holds `pwm_out` high while the waveform runs.
- R9: Every control-word write commits both held counts. The new high phase starts in the cycle right after that write.
- R10: A write to any other offset changes no register, and a read from any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | ADDR_W (5) | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
A control-word write sampled at edge k commits the counts. `pwm_out` then shows the first high cycle in the clock period that follows edge k, with no added latency. A count write at edge k shows up in read data straight after that edge, and it never shows up on the output. Read data follows `reg_addr` with no clock at all.

The bench drives inputs and samples `pwm_out` only on falling edges. It keeps a cycle index that it resets to zero on every control-word write and advances once per falling edge. At each sample it compares the output with the value a reference function computes from that index and the counts the bench itself believes are committed.

// File: rtl/pwm_onoff_pkg.sv
package pwm_onoff_pkg;
  localparam int REG_W = 32;

  // register offsets (bytes)
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_LOW  = 'h18;
  localparam int OFS_HIGH = 'h1C;

  // control bit positions that gate the output
  localparam int BIT_RUN   = 0;
  localparam int BIT_DRIVE = 14;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/pwm_onoff_regs.sv
module pwm_onoff_regs
  import pwm_onoff_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [CNT_W-1:0]  hold_high,
  output logic [CNT_W-1:0]  hold_low,
  output logic              commit,
  output logic              commit_run
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFS_LOW);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFS_HIGH);

  logic sel_ctrl, sel_low, sel_high;
  assign sel_ctrl = (addr == A_CTRL);
  assign sel_low  = (addr == A_LOW);
  assign sel_high = (addr == A_HIGH);

  assign commit     = we && sel_ctrl;
  assign commit_run = wdata[BIT_RUN] && wdata[BIT_DRIVE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      hold_high <= '0;
      hold_low  <= '0;
    end else if (we) begin
      if (sel_ctrl) ctrl_q    <= wdata;
      if (sel_low)  hold_low  <= wdata[CNT_W-1:0];
      if (sel_high) hold_high <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)      rdata = ctrl_q;
    else if (sel_low)  rdata = REG_W'(hold_low);
    else if (sel_high) rdata = REG_W'(hold_high);
  end

  assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel_ctrl && !sel_low && !sel_high) |=>
      ($stable(ctrl_q) && $stable(hold_high) && $stable(hold_low)));
endmodule

// File: rtl/pwm_onoff_phase.sv
module pwm_onoff_phase
  import pwm_onoff_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             commit_run,
  input  logic [CNT_W-1:0] hold_high,
  input  logic [CNT_W-1:0] hold_low,
  output logic             run_q,
  output phase_e           phase_q,
  output logic [CNT_W-1:0] act_high,
  output logic [CNT_W-1:0] act_low
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic high_done, low_done;
  assign high_done = (cnt_q == act_high - ONE);
  assign low_done  = (act_low == '0) || (cnt_q == act_low - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
      act_high <= '0;
      act_low  <= '0;
    end else if (commit) begin
      act_high <= hold_high;
      act_low  <= hold_low;
      run_q    <= commit_run;
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
    end else if (run_q) begin
      unique case (phase_q)
        PH_HIGH: begin
          if (act_high == '0) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end else if (high_done) begin
            cnt_q <= '0;
            if (act_low != '0) phase_q <= PH_LOW;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        PH_LOW: begin
          if (low_done) begin
            cnt_q <= '0;
            if (act_high != '0) phase_q <= PH_HIGH;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        default: begin
          phase_q <= PH_HIGH;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assert_high_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && phase_q == PH_HIGH && act_high != '0) |-> (cnt_q < act_high));
  assert_low_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && phase_q == PH_LOW && act_low != '0) |-> (cnt_q < act_low));
  assert_counts_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_high) && $stable(act_low)));
endmodule

// File: rtl/pwm_onoff_gate.sv
module pwm_onoff_gate
  import pwm_onoff_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             run,
  input  phase_e           phase,
  input  logic [CNT_W-1:0] act_high,
  output logic             pwm_out
);
  assign pwm_out = run && (phase == PH_HIGH) && (act_high != '0);
endmodule

// File: rtl/pwm_onoff_top.sv
module pwm_onoff_top
  import pwm_onoff_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pwm_out
);
  logic [REG_W-1:0] ctrl_q;
  logic [CNT_W-1:0] hold_high, hold_low, act_high, act_low;
  logic commit, commit_run, run_q;
  phase_e phase_q;

  pwm_onoff_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl_q(ctrl_q), .hold_high(hold_high), .hold_low(hold_low),
    .commit(commit), .commit_run(commit_run)
  );

  pwm_onoff_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_run(commit_run),
    .hold_high(hold_high), .hold_low(hold_low), .run_q(run_q), .phase_q(phase_q),
    .act_high(act_high), .act_low(act_low)
  );

  pwm_onoff_gate #(.CNT_W(CNT_W)) u_gate (
    .run(run_q), .phase(phase_q), .act_high(act_high), .pwm_out(pwm_out)
  );

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q[BIT_RUN] && ctrl_q[BIT_DRIVE]) |-> !pwm_out);
  assert_restart_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_run && hold_high != '0) |=> pwm_out);
  assert_zero_high_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_high == '0) |-> !pwm_out);
  assert_zero_low_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && act_high != '0 && act_low == '0 && !commit) |=> pwm_out);
endmodule

// File: tb/sim_pwm_onoff_top.sv
`timescale 1ns/1ps
module sim_pwm_onoff_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_ctrl = '0, m_hi = '0, m_lo = '0;
  longint a_hi = 0, a_lo = 0, t = 0;
  bit a_run = 0;

  always #2.5 clk = ~clk;

  pwm_onoff_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  function automatic bit exp_out(bit run, longint hi, longint lo, longint idx);
    if (!run || hi == 0) return 1'b0;
    if (lo == 0) return 1'b1;
    return (idx % (hi + lo)) < hi;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a == 5'h00) begin
      m_ctrl = d; a_hi = m_hi; a_lo = m_lo; a_run = d[0] && d[14]; t = -1;
    end else if (a == 5'h18) m_lo = d;
    else if (a == 5'h1C) m_hi = d;
    @(negedge clk);
    reg_we = 1'b0;
    t++;
  endtask

  task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic watch(string req, int n);
    for (int i = 0; i < n; i++) begin
      check(req, {31'b0, pwm_out}, {31'b0, exp_out(a_run, a_hi, a_lo, t)});
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1", 5'h00, 32'h0); rd("R1", 5'h18, 32'h0); rd("R1", 5'h1C, 32'h0);
    check("R1", {31'b0, pwm_out}, 32'h0);

    // R2 / R4: counts held while control is zero
    wr(5'h1C, 32'd3); wr(5'h18, 32'd2);
    rd("R2", 5'h1C, 32'd3); rd("R2", 5'h18, 32'd2);
    watch("R4", 6);
    // R6 normal waveform
    wr(5'h00, 32'h4021);
    rd("R3", 5'h00, 32'h4021);
    watch("R6", 20);
    // R4 shadow writes during run
    wr(5'h1C, 32'd5); wr(5'h18, 32'd5);
    watch("R4", 12);
    // R9 restart with new counts
    wr(5'h00, 32'h4001);
    watch("R9", 25);
    // R7 high count zero
    wr(5'h1C, 32'd0); wr(5'h18, 32'd4); wr(5'h00, 32'h4001);
    watch("R7", 10);
    wr(5'h18, 32'd0); wr(5'h00, 32'h4001);
    watch("R7", 6);
    // R8 low count zero
    wr(5'h1C, 32'd4); wr(5'h00, 32'h4001);
    watch("R8", 10);
    // R5 only one of the gating bits
    wr(5'h18, 32'd2); wr(5'h00, 32'h0001);
    watch("R5", 8);
    wr(5'h00, 32'h4000);
    watch("R5", 8);
    // R3 extra bits stored, no effect
    wr(5'h00, 32'h4605);
    rd("R3", 5'h00, 32'h4605);
    watch("R3", 15);
    // R10 unmapped offsets
    wr(5'h04, 32'hDEAD_BEEF); wr(5'h1A, 32'h1234_5678);
    rd("R10", 5'h04, 32'h0); rd("R10", 5'h1A, 32'h0);
    rd("R10", 5'h00, 32'h4605); rd("R10", 5'h1C, 32'd4); rd("R10", 5'h18, 32'd2);
    watch("R10", 6);
    // R2 full 32-bit width
    wr(5'h1C, 32'hFFFF_FFFF); rd("R2", 5'h1C, 32'hFFFF_FFFF);

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [31:0] c;
      wr(5'h1C, $urandom_range(0, 12));
      wr(5'h18, $urandom_range(0, 12));
      c = $urandom & 32'h0000_4625;
      if ($urandom_range(0, 3) != 0) c = c | 32'h4001;
      watch("R4", $urandom_range(1, 5));
      wr(5'h00, c);
      rd("R3", 5'h00, c);
      watch("R6", $urandom_range(10, 40));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule